// File: doc/BRIEF.md
# Addressed Asynchronous Serial Receiver

This block receives asynchronous serial frames and supports multidrop addressing. A start bit opens each frame. Eight data bits follow, least significant bit first, and a stop bit closes the frame. When addressed mode is on, one extra address-marker bit sits between the data and the stop bit. A marker of 1 labels the frame as an address (ID) frame. A marker of 0 labels it as a payload frame. The line is sampled through a 16x oversampling counter that advances on an external sample-tick enable. Each bit is taken near its middle.

Software can arm a listen filter. While the filter is armed and addressed mode is on, payload frames leave no trace: no byte transfer, no error flag and no data-ready flag. The first frame whose marker is 1 is accepted normally. That frame sets the marker status flag and disarms the filter in hardware. Software then inspects the received address and decides whether to keep listening. The accepted byte is held in a data register. Status flags and two interrupt requests report the receiver's state to software.

Top module: `mpr_serial_rx`

## Requirements
- R1: After reset, rx_data is 0, st_full, st_fer, st_ovr, st_mpb and filt_en are 0, and both interrupt requests are 0.
- R2: A frame is a low start bit, then 8 data bits LSB first, then, only when ctl_mp_mode is 1, one marker bit, then the stop bit. An accepted frame with st_full at 0 loads its byte into rx_data and sets st_full.
- R3: A frame begins only on a low line seen while ctl_rx_en is 1. A start bit that reads high again at its midpoint is discarded, and frames sent while ctl_rx_en is 0 change nothing.
- R4: Clearing ctl_rx_en leaves st_full, st_fer, st_ovr and rx_data at their current values.
- R5: An accepted frame whose stop bit is sampled 0 sets st_fer. The byte is still handled as in R2 and R6.
- R6: An accepted frame that completes while st_full is 1 sets st_ovr and leaves rx_data unchanged.
- R7: With ctl_mp_mode at 0, filt_en has no effect and every frame is accepted.
- R8: With ctl_mp_mode at 1 and filt_en at 1, a frame whose marker is 0 leaves rx_data, st_full, st_fer, st_ovr and st_mpb unchanged.
- R9: With ctl_mp_mode at 1, a frame whose marker is 1 is accepted, sets st_mpb and clears filt_en. This hardware clear wins over a filter write made in the same cycle.
- R10: rx_irq is st_full AND ctl_rxi_en. err_irq is (st_fer OR st_ovr) AND ctl_eri_en.
- R11: filt_wr loads filt_wdata into filt_en. A 1 on flag_clr bit 0, 1, 2 or 3 clears st_full, st_fer, st_ovr or st_mpb respectively. A flag set in the same cycle wins over its clear.
- R12: In addressed mode, each accepted frame copies its marker bit into st_mpb. Frames received with ctl_mp_mode at 0 leave st_mpb unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd | input | 1 | Serial line, idle high |
| tick | input | 1 | Oversampling enable, 16 per bit time |
| ctl_rx_en | input | 1 | Receiver enable |
| ctl_mp_mode | input | 1 | Addressed mode (frames carry a marker bit) |
| ctl_rxi_en | input | 1 | Data-ready interrupt enable |
| ctl_eri_en | input | 1 | Error interrupt enable |
| filt_wr | input | 1 | Write strobe for the listen filter |
| filt_wdata | input | 1 | Value written to the listen filter |
| flag_clr | input | 4 | Flag clear strobes: 0 full, 1 framing, 2 overrun, 3 marker |
| rx_data | output | 8 | Last accepted byte |
| st_full | output | 1 | Data-ready flag |
| st_fer | output | 1 | Framing error flag |
| st_ovr | output | 1 | Overrun flag |
| st_mpb | output | 1 | Marker bit of the last accepted addressed frame |
| filt_en | output | 1 | Listen filter state |
| rx_irq | output | 1 | Data-ready interrupt request |
| err_irq | output | 1 | Error interrupt request |

## Verification
On every cycle, the assertions check the following:
- A disabled receiver falls back to idle.
- A false start is dropped.
- Flags hold while the receiver is off.
- A filtered payload frame changes nothing.
- An address frame disarms the filter and raises the marker flag.
- An overrun keeps the held byte.

Only the bench's scenarios can show the rest:
- Bit order and sampling over the line's timing.
- Byte values across the full 8-bit range.
- Frame length in each mode.
- The ordered filter sequence: arm, ignore payload frames, wake on an address frame, then detect an overrun once disarmed.

// File: rtl/mpr_pkg.sv
package mpr_pkg;
  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_e;
  localparam int CLR_W    = 4;
  localparam int CLR_FULL = 0;
  localparam int CLR_FER  = 1;
  localparam int CLR_OVR  = 2;
  localparam int CLR_MPB  = 3;
endpackage

// File: rtl/mpr_rst_sync.sv
module mpr_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [1:0] stg_q;
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stg_q <= 2'b00;
    else         stg_q <= {stg_q[0], 1'b1};
  end
  assign rst_n_o = stg_q[1];
endmodule

// File: rtl/mpr_in_sync.sv
module mpr_in_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= {chain_q[STAGES-2:0], d};
  end
  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/mpr_rx_engine.sv
module mpr_rx_engine
  import mpr_pkg::*;
#(
  parameter int DW  = 8,
  parameter int OVS = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_en,
  input  logic          mp_mode,
  input  logic          tick,
  input  logic          rxd_s,
  output logic          done,
  output logic [DW-1:0] frame_data,
  output logic          frame_mp,
  output logic          stop_ok
);
  localparam int CW  = $clog2(OVS);
  localparam int BW  = $clog2(DW + 2);
  localparam int MID = OVS / 2 - 1;

  rx_state_e     st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [BW-1:0] bit_q, bit_d, last_bit;
  logic [DW:0]   sh_q, sh_d;
  logic          cnt_full, cnt_mid;

  assign last_bit = mp_mode ? BW'(DW) : BW'(DW - 1);
  assign cnt_full = (cnt_q == CW'(OVS - 1));
  assign cnt_mid  = (cnt_q == CW'(MID));

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    bit_d = bit_q;
    sh_d  = sh_q;
    if (!rx_en) begin
      st_d  = RX_IDLE;
      cnt_d = '0;
      bit_d = '0;
    end else if (tick) begin
      case (st_q)
        RX_IDLE: begin
          if (!rxd_s) begin
            st_d  = RX_START;
            cnt_d = '0;
          end
        end
        RX_START: begin
          cnt_d = cnt_q + 1'b1;
          if (cnt_mid) begin
            cnt_d = '0;
            bit_d = '0;
            st_d  = rxd_s ? RX_IDLE : RX_DATA;
          end
        end
        RX_DATA: begin
          cnt_d = cnt_q + 1'b1;
          if (cnt_full) begin
            cnt_d = '0;
            sh_d  = {rxd_s, sh_q[DW:1]};
            bit_d = bit_q + 1'b1;
            if (bit_q == last_bit) st_d = RX_STOP;
          end
        end
        RX_STOP: begin
          cnt_d = cnt_q + 1'b1;
          if (cnt_full) begin
            cnt_d = '0;
            st_d  = RX_IDLE;
          end
        end
        default: st_d = RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= RX_IDLE;
      cnt_q <= '0;
      bit_q <= '0;
      sh_q  <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      bit_q <= bit_d;
      sh_q  <= sh_d;
    end
  end

  assign done       = rx_en & tick & (st_q == RX_STOP) & cnt_full;
  assign stop_ok    = rxd_s;
  assign frame_data = mp_mode ? sh_q[DW-1:0] : sh_q[DW:1];
  assign frame_mp   = mp_mode & sh_q[DW];

  // R3
  idle_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (st_q == RX_IDLE));

  // R3
  false_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && tick && st_q == RX_START && cnt_mid && rxd_s) |=> (st_q == RX_IDLE));

  // R2
  bit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == RX_DATA) |-> (bit_q <= BW'(DW)));
endmodule

// File: rtl/mpr_rx_flags.sv
module mpr_rx_flags
  import mpr_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             done,
  input  logic [DW-1:0]    frame_data,
  input  logic             frame_mp,
  input  logic             stop_ok,
  input  logic             mp_mode,
  input  logic             filt_wr,
  input  logic             filt_wdata,
  input  logic [CLR_W-1:0] flag_clr,
  input  logic             rxi_en,
  input  logic             eri_en,
  output logic [DW-1:0]    rx_data,
  output logic             full,
  output logic             fer,
  output logic             ovr,
  output logic             mpb,
  output logic             filt,
  output logic             rx_irq,
  output logic             err_irq
);
  logic [DW-1:0] data_q, data_d;
  logic full_q, full_d, fer_q, fer_d, ovr_q, ovr_d, mpb_q, mpb_d, filt_q, filt_d;
  logic filt_act, accept, wake;

  assign filt_act = filt_q & mp_mode;
  assign accept   = done & (~filt_act | frame_mp);
  assign wake     = done & mp_mode & frame_mp;

  always_comb begin
    data_d = data_q;
    if (accept && !full_q) data_d = frame_data;
    full_d = accept | (full_q & ~flag_clr[CLR_FULL]);
    fer_d  = (accept & ~stop_ok) | (fer_q & ~flag_clr[CLR_FER]);
    ovr_d  = (accept & full_q) | (ovr_q & ~flag_clr[CLR_OVR]);
    if (accept && mp_mode) mpb_d = frame_mp;
    else                   mpb_d = mpb_q & ~flag_clr[CLR_MPB];
    if (wake)         filt_d = 1'b0;
    else if (filt_wr) filt_d = filt_wdata;
    else              filt_d = filt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      full_q <= 1'b0;
      fer_q  <= 1'b0;
      ovr_q  <= 1'b0;
      mpb_q  <= 1'b0;
      filt_q <= 1'b0;
    end else begin
      data_q <= data_d;
      full_q <= full_d;
      fer_q  <= fer_d;
      ovr_q  <= ovr_d;
      mpb_q  <= mpb_d;
      filt_q <= filt_d;
    end
  end

  assign rx_data = data_q;
  assign full    = full_q;
  assign fer     = fer_q;
  assign ovr     = ovr_q;
  assign mpb     = mpb_q;
  assign filt    = filt_q;
  assign rx_irq  = full_q & rxi_en;
  assign err_irq = (fer_q | ovr_q) & eri_en;

  // R8
  filtered_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && mp_mode && filt_q && !frame_mp && flag_clr == '0)
    |=> ($stable(data_q) && $stable(full_q) && $stable(fer_q) && $stable(ovr_q) && $stable(mpb_q)));

  // R9
  wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && mp_mode && frame_mp) |=> (!filt_q && mpb_q && full_q));

  // R6
  overrun_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && full_q && (!mp_mode || !filt_q || frame_mp)) |=> (ovr_q && $stable(data_q)));
endmodule

// File: rtl/mpr_serial_rx.sv
module mpr_serial_rx
  import mpr_pkg::*;
#(
  parameter int DW          = 8,
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rxd,
  input  logic             tick,
  input  logic             ctl_rx_en,
  input  logic             ctl_mp_mode,
  input  logic             ctl_rxi_en,
  input  logic             ctl_eri_en,
  input  logic             filt_wr,
  input  logic             filt_wdata,
  input  logic [CLR_W-1:0] flag_clr,
  output logic [DW-1:0]    rx_data,
  output logic             st_full,
  output logic             st_fer,
  output logic             st_ovr,
  output logic             st_mpb,
  output logic             filt_en,
  output logic             rx_irq,
  output logic             err_irq
);
  logic          rst_n_i, rxd_s, done, frame_mp, stop_ok;
  logic [DW-1:0] frame_data;

  mpr_rst_sync u_rst (.clk(clk), .arst_n(rst_n), .rst_n_o(rst_n_i));

  mpr_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n_i), .d(rxd), .q(rxd_s));

  mpr_rx_engine #(.DW(DW), .OVS(OVS)) u_eng (
    .clk(clk), .rst_n(rst_n_i), .rx_en(ctl_rx_en), .mp_mode(ctl_mp_mode),
    .tick(tick), .rxd_s(rxd_s), .done(done), .frame_data(frame_data),
    .frame_mp(frame_mp), .stop_ok(stop_ok));

  mpr_rx_flags #(.DW(DW)) u_flags (
    .clk(clk), .rst_n(rst_n_i), .done(done), .frame_data(frame_data),
    .frame_mp(frame_mp), .stop_ok(stop_ok), .mp_mode(ctl_mp_mode),
    .filt_wr(filt_wr), .filt_wdata(filt_wdata), .flag_clr(flag_clr),
    .rxi_en(ctl_rxi_en), .eri_en(ctl_eri_en), .rx_data(rx_data),
    .full(st_full), .fer(st_fer), .ovr(st_ovr), .mpb(st_mpb),
    .filt(filt_en), .rx_irq(rx_irq), .err_irq(err_irq));

  // R4
  hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    (!ctl_rx_en && flag_clr == '0)
    |=> ($stable(st_full) && $stable(st_fer) && $stable(st_ovr) && $stable(rx_data)));
endmodule

// File: tb/sim_mpr_serial_rx.sv
module sim_mpr_serial_rx;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rxd = 1'b1, tick = 1'b0;
  logic rx_en = 1'b0, mp_mode = 1'b0, rxi_en = 1'b0, eri_en = 1'b0;
  logic filt_wr = 1'b0, filt_wdata = 1'b0;
  logic [3:0] flag_clr = 4'h0;
  logic [7:0] rx_data;
  logic st_full, st_fer, st_ovr, st_mpb, filt_en, rx_irq, err_irq;
  int tests = 0, fails = 0, tdiv = 2, tcnt = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  always @(negedge clk) begin
    if (tcnt >= tdiv - 1) begin tcnt = 0; tick = 1'b1; end
    else begin tcnt = tcnt + 1; tick = 1'b0; end
  end

  mpr_serial_rx u0 (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .tick(tick), .ctl_rx_en(rx_en),
    .ctl_mp_mode(mp_mode), .ctl_rxi_en(rxi_en), .ctl_eri_en(eri_en),
    .filt_wr(filt_wr), .filt_wdata(filt_wdata), .flag_clr(flag_clr),
    .rx_data(rx_data), .st_full(st_full), .st_fer(st_fer), .st_ovr(st_ovr),
    .st_mpb(st_mpb), .filt_en(filt_en), .rx_irq(rx_irq), .err_irq(err_irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hold_bit(input logic v, input int ticks);
    rxd = v;
    repeat (ticks * tdiv) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] b, input logic mp, input logic use_mp, input logic stp);
    @(negedge clk);
    hold_bit(1'b0, 16);
    for (int i = 0; i < 8; i++) hold_bit(b[i], 16);
    if (use_mp) hold_bit(mp, 16);
    hold_bit(stp, stp ? 16 : 13);
    hold_bit(1'b1, 40);
  endtask

  task automatic clr(input logic [3:0] m);
    @(negedge clk); flag_clr = m;
    @(negedge clk); flag_clr = 4'h0;
    @(negedge clk);
  endtask

  task automatic wfilt(input logic v);
    @(negedge clk); filt_wr = 1'b1; filt_wdata = v;
    @(negedge clk); filt_wr = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 data", rx_data, 0);
    chk("R1 flags", {st_full, st_fer, st_ovr, st_mpb, filt_en}, 0);
    chk("R1 irq", {rx_irq, err_irq}, 0);

    rx_en = 1'b1; mp_mode = 1'b1; rxi_en = 1'b1; eri_en = 1'b1;

    // R2 R12 R10: sweep every byte value, marker derived from the byte
    tdiv = 1;
    repeat (4) @(negedge clk);
    for (int b = 0; b < 256; b++) begin
      logic m;
      m = b[0] ^ b[3];
      send(8'(b), m, 1'b1, 1'b1);
      chk("R2 data", rx_data, b);
      chk("R2 full", st_full, 1);
      chk("R12 marker", st_mpb, m);
      chk("R10 rx_irq", rx_irq, 1);
      chk("R5 no fer", {st_fer, st_ovr}, 0);
      clr(4'b0001);
    end
    tdiv = 2;
    repeat (4) @(negedge clk);

    // R10 interrupt gating
    send(8'h5A, 1'b1, 1'b1, 1'b1);
    rxi_en = 1'b0;
    @(negedge clk);
    chk("R10 rx_irq masked", rx_irq, 0);
    rxi_en = 1'b1;
    @(negedge clk);
    chk("R12 marker set", st_mpb, 1);
    clr(4'b1111);
    send(8'h5B, 1'b1, 1'b1, 1'b1);
    clr(4'b0001);

    // R2 R12: 10-bit frame in plain mode leaves marker flag alone
    mp_mode = 1'b0;
    send(8'hA5, 1'b0, 1'b0, 1'b1);
    chk("R2 plain data", rx_data, 8'hA5);
    chk("R12 marker kept", st_mpb, 1);
    clr(4'b1111);
    mp_mode = 1'b1;

    // R5 framing error
    send(8'h3C, 1'b0, 1'b1, 1'b0);
    chk("R5 fer", st_fer, 1);
    chk("R5 data", rx_data, 8'h3C);
    chk("R10 err_irq", err_irq, 1);
    clr(4'b1111);
    chk("R11 clear", {st_full, st_fer, st_ovr, st_mpb}, 0);

    // R6 overrun
    send(8'h11, 1'b0, 1'b1, 1'b1);
    send(8'h22, 1'b0, 1'b1, 1'b1);
    chk("R6 ovr", st_ovr, 1);
    chk("R6 data kept", rx_data, 8'h11);
    clr(4'b1110);

    // R8 filtered payload frames
    wfilt(1'b1);
    chk("R11 filt write", filt_en, 1);
    send(8'h44, 1'b0, 1'b1, 1'b0);
    chk("R8 data", rx_data, 8'h11);
    chk("R8 flags", {st_full, st_fer, st_ovr, st_mpb}, 4'b1000);
    chk("R8 filt kept", filt_en, 1);
    clr(4'b0001);
    send(8'h55, 1'b0, 1'b1, 1'b1);
    chk("R8 no full", st_full, 0);
    chk("R8 data2", rx_data, 8'h11);

    // R9 address frame wakes
    send(8'h66, 1'b1, 1'b1, 1'b1);
    chk("R9 data", rx_data, 8'h66);
    chk("R9 full", st_full, 1);
    chk("R9 marker", st_mpb, 1);
    chk("R9 filt cleared", filt_en, 0);
    chk("R9 rx_irq", rx_irq, 1);
    send(8'h67, 1'b0, 1'b1, 1'b1);
    chk("R6 ovr after wake", st_ovr, 1);
    clr(4'b1111);

    // R7 filter ignored in plain mode
    mp_mode = 1'b0;
    wfilt(1'b1);
    send(8'h77, 1'b0, 1'b0, 1'b1);
    chk("R7 data", rx_data, 8'h77);
    chk("R7 full", st_full, 1);
    chk("R7 filt stays", filt_en, 1);
    wfilt(1'b0);
    chk("R11 filt cleared", filt_en, 0);
    mp_mode = 1'b1;

    // R4 R3 receiver off
    rx_en = 1'b0;
    repeat (3) @(negedge clk);
    chk("R4 full held", st_full, 1);
    chk("R4 data held", rx_data, 8'h77);
    send(8'h88, 1'b0, 1'b1, 1'b1);
    chk("R3 off data", rx_data, 8'h77);
    chk("R3 off ovr", st_ovr, 0);
    rx_en = 1'b1;
    clr(4'b1111);

    // R3 false start then good frame
    @(negedge clk);
    hold_bit(1'b0, 4);
    hold_bit(1'b1, 48);
    chk("R3 false start", {st_full, st_fer, st_ovr}, 0);
    send(8'h99, 1'b0, 1'b1, 1'b1);
    chk("R3 after false", rx_data, 8'h99);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule